// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a request, made of a sequence of scatter-gather segments (each a 32-bit bus address and a byte length), into the physical-region-descriptor words that a bus-mastering disk controller fetches. Segments arrive one per valid/ready handshake, and a last flag closes the request. Each descriptor leaves as two 32-bit words on a valid/ready output stream: first the buffer address, then the count word. Writing the words into memory, and the transfer itself, belong to other blocks.

Segments are cut so that no descriptor spans a 64 KB address boundary. In the normal encoding the byte count sits in the low 16 bits, so a full 64 KB piece cannot be expressed. Such a piece is emitted as two 32 KB descriptors, because some controllers read a zero count as an empty buffer. A mode input selects an alternate encoding in which the count word carries the number of 32-bit words minus one in its upper half. Bit 31 of the final count word flags the end of the table. When the request ends, a one-cycle done pulse reports either the number of descriptors built or a failure. A request fails when it exceeds the descriptor limit or when it yields no descriptor at all.

Top module: `prd_table_gen`

## Requirements
- R1: Each descriptor leaves as two words, the address word first and the count word second. In normal mode (alt_mode = 0) the count word carries the byte count in bits 15:0 and zeros in bits 30:16.
- R2: No descriptor crosses a 64 KB boundary. Each piece is the smaller of the bytes left in the segment and 0x10000 minus the low 16 address bits, and the next piece starts at the address that follows it.
- R3: In normal mode, a piece of exactly 0x10000 bytes is emitted as two descriptors, (addr, 0x8000) and (addr + 0x8000, 0x8000).
- R4: In alternate mode (alt_mode = 1), the count word equals ((bytes >> 2) - 1) << 16, with bits 15:0 zero. A 0x10000-byte piece stays a single descriptor. Segments in this mode are assumed to be 4-byte aligned.
- R5: Bit 31 of the count word is set on the final descriptor of a successful request and clear on every other count word.
- R6: If the request needs more than MAX_ENTRIES descriptors, done rises with fail = 1 and entry_count = 0. The remaining segments of the request, up to and including the one flagged last, are accepted and dropped. A request of exactly MAX_ENTRIES descriptors succeeds.
- R7: A request whose segments all have zero length produces no descriptor, and done rises with fail = 1 and entry_count = 0. A zero-length segment inside a request contributes nothing.
- R8: On success, done is high for exactly one cycle with fail = 0 and entry_count equal to the number of descriptors emitted. The next request then starts from a count of zero.
- R9: While desc_valid is high and desc_ready is low, desc_word holds its value. seg_ready is never high in the same cycle as desc_valid.
- R10: After reset, seg_ready is 1 and desc_valid, done and fail are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alt_mode | input | 1 | 1 selects the word-count encoding; held constant for a request |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high with seg_valid |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | 32 | Segment length in bytes |
| seg_last | input | 1 | Segment closes the request |
| desc_valid | output | 1 | Descriptor word offered |
| desc_ready | input | 1 | Consumer takes the word |
| desc_word | output | 32 | Address word or count word |
| done | output | 1 | One-cycle pulse at the end of a request |
| fail | output | 1 | Request failed, valid with done |
| entry_count | output | CNT_W | Descriptors built, valid with done; 0 on failure |

## Verification
The bench aims at a segment that straddles a 64 KB boundary: a design that fails to split it would emit one descriptor whose range wraps. It sends 64 KB pieces in both encodings. A normal-mode design without the halving would emit a zero count, and an alternate-mode design that halves would emit two entries. It runs requests of exactly the limit and one past it, a request made only of empty segments, and an empty segment between full ones. A wrong limit comparison, or a missing failure path, then shows up as a wrong count, a hang, or segments left unconsumed. Throttled output checks that held words stay stable and that only the last count word carries the end bit.

// File: rtl/prd_pkg.sv
// Package: shared state encoding and descriptor type for the table builder.
// Assumes 32-bit addresses and 32-bit descriptor words.
package prd_pkg;

    typedef enum logic [2:0] {
        ST_IN    = 3'd0,   // waiting for a segment
        ST_SPLIT = 3'd1,   // cutting the current segment into pieces
        ST_OUT_A = 3'd2,   // presenting the address word of the held entry
        ST_OUT_C = 3'd3,   // presenting the count word of the held entry
        ST_DRAIN = 3'd4,   // discarding segments after a failure
        ST_DONE  = 3'd5    // reporting the result for one cycle
    } prd_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] cnt;
    } prd_desc_t;

    localparam int END_BIT   = 31;
    localparam int WIN_BITS  = 16;   // a descriptor stays inside a 2**16 byte window

endpackage

// File: rtl/prd_chunk_calc.sv
// Module: prd_chunk_calc
// Works out the size of the next piece of a segment so that the piece ends
// at or before the next 64 KB boundary. In normal mode a full 64 KB piece is
// clamped to 32 KB; the following piece then starts on the 32 KB mark, which
// yields the two-halves split. Purely combinational.
module prd_chunk_calc #(
    parameter int LEN_W = 32
) (
    input  logic [15:0]      addr_lo,
    input  logic [LEN_W-1:0] rem_len,
    input  logic             alt_mode,
    output logic [16:0]      chunk
);
    localparam logic [16:0] WINDOW = 17'h10000;
    localparam logic [16:0] HALF   = 17'h08000;

    logic [16:0] room;
    logic        rem_small;
    logic [16:0] raw;

    // Bytes left before the next boundary.
    always_comb room = WINDOW - {1'b0, addr_lo};

    // Whether the segment ends before the boundary.
    always_comb rem_small = (rem_len < LEN_W'(room));

    // Piece size, halved when the normal count field cannot hold it.
    always_comb begin
        raw = rem_small ? rem_len[16:0] : room;
        if (!alt_mode && raw == WINDOW)
            chunk = HALF;
        else
            chunk = raw;
    end
endmodule

// File: rtl/prd_count_encode.sv
// Module: prd_count_encode
// Builds the count word for a piece. Normal mode: byte count in bits 15:0.
// Alternate mode: (bytes/4 - 1) in the upper half. Bit 31 is left clear;
// the end marker is applied at output time. Assumes bytes is non-zero and,
// in alternate mode, a multiple of four.
module prd_count_encode (
    input  logic [16:0] bytes,
    input  logic        alt_mode,
    output logic [31:0] cnt_word
);
    logic [14:0] words_m1;

    // Word count minus one for the alternate encoding.
    always_comb words_m1 = bytes[16:2] - 15'd1;

    // Select the encoding.
    always_comb begin
        if (alt_mode)
            cnt_word = {1'b0, words_m1, 16'h0000};
        else
            cnt_word = {16'h0000, bytes[15:0]};
    end
endmodule

// File: rtl/prd_desc_hold.sv
// Module: prd_desc_hold
// Two-deep holding store for descriptors. The held entry is released only
// once a later entry exists or the request has ended, so the end marker can
// be set on the right count word. Drives the word shown on the output.
module prd_desc_hold (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                push,
    input  prd_pkg::prd_desc_t  new_desc,
    input  logic                shift,
    input  logic                sel_cnt,
    input  logic                mark_end,
    output logic                has_pend,
    output logic [31:0]         out_word
);
    import prd_pkg::*;

    prd_desc_t pend_q;
    prd_desc_t next_q;

    // Holds the oldest unreleased entry and the one that follows it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            has_pend <= 1'b0;
            pend_q   <= '0;
            next_q   <= '0;
        end else if (push) begin
            if (has_pend) begin
                next_q <= new_desc;
            end else begin
                pend_q   <= new_desc;
                has_pend <= 1'b1;
            end
        end else if (shift) begin
            pend_q <= next_q;
        end
    end

    // Output word: address, or count with the end marker when asked.
    always_comb begin
        if (sel_cnt) begin
            out_word          = pend_q.cnt;
            out_word[END_BIT] = mark_end;
        end else begin
            out_word = pend_q.addr;
        end
    end
endmodule

// File: rtl/prd_table_gen.sv
// Module: prd_table_gen (top)
// Accepts scatter-gather segments, cuts them into boundary-safe pieces,
// encodes each piece as an address word and a count word, marks the last
// count word, enforces MAX_ENTRIES and reports the result with a done pulse.
// Assumes alt_mode is stable for the whole request.
module prd_table_gen #(
    parameter int MAX_ENTRIES = 256,
    parameter int LEN_W       = 32,
    parameter int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_mode,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [31:0]      seg_addr,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             seg_last,
    output logic             desc_valid,
    input  logic             desc_ready,
    output logic [31:0]      desc_word,
    output logic             done,
    output logic             fail,
    output logic [CNT_W-1:0] entry_count
);
    import prd_pkg::*;

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ENTRIES);

    prd_state_e       state_q, state_d;
    logic [31:0]      addr_q;
    logic [LEN_W-1:0] rem_q;
    logic             last_q;
    logic             alt_q;
    logic             fin_q;
    logic             fail_q;
    logic [CNT_W-1:0] cnt_q;

    logic [16:0]      chunk;
    logic [31:0]      cnt_word;
    prd_desc_t        new_desc;
    logic             has_pend;
    logic             seg_take;
    logic             out_take;
    logic             rem_zero;
    logic             at_limit;
    logic             do_push;
    logic             do_shift;
    logic             do_clear;

    prd_chunk_calc #(.LEN_W(LEN_W)) u_chunk (
        .addr_lo  (addr_q[WIN_BITS-1:0]),
        .rem_len  (rem_q),
        .alt_mode (alt_q),
        .chunk    (chunk)
    );

    prd_count_encode u_enc (
        .bytes    (chunk),
        .alt_mode (alt_q),
        .cnt_word (cnt_word)
    );

    // Descriptor built from the current piece.
    always_comb begin
        new_desc.addr = addr_q;
        new_desc.cnt  = cnt_word;
    end

    prd_desc_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (do_clear),
        .push     (do_push),
        .new_desc (new_desc),
        .shift    (do_shift),
        .sel_cnt  (state_q == ST_OUT_C),
        .mark_end (fin_q),
        .has_pend (has_pend),
        .out_word (desc_word)
    );

    // Handshake and condition decode.
    always_comb begin
        seg_ready  = (state_q == ST_IN) || (state_q == ST_DRAIN);
        desc_valid = (state_q == ST_OUT_A) || (state_q == ST_OUT_C);
        seg_take   = seg_ready && seg_valid;
        out_take   = desc_valid && desc_ready;
        rem_zero   = (rem_q == '0);
        at_limit   = (cnt_q == MAX_CNT);
        do_push    = (state_q == ST_SPLIT) && !rem_zero && !at_limit;
        do_shift   = (state_q == ST_OUT_C) && out_take && !fin_q;
        do_clear   = (state_q == ST_DONE);
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IN:    if (seg_take) state_d = ST_SPLIT;
            ST_SPLIT: begin
                if (rem_zero) begin
                    if (!last_q)       state_d = ST_IN;
                    else if (has_pend) state_d = ST_OUT_A;
                    else               state_d = ST_DONE;
                end else if (at_limit) begin
                    state_d = last_q ? ST_DONE : ST_DRAIN;
                end else if (has_pend) begin
                    state_d = ST_OUT_A;
                end
            end
            ST_OUT_A: if (out_take) state_d = ST_OUT_C;
            ST_OUT_C: if (out_take) state_d = fin_q ? ST_DONE : ST_SPLIT;
            ST_DRAIN: if (seg_take && seg_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IN;
            default:  state_d = ST_IN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IN;
        else        state_q <= state_d;
    end

    // Segment registers: load on accept, advance by one piece per push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            last_q <= 1'b0;
            alt_q  <= 1'b0;
        end else if (state_q == ST_IN && seg_take) begin
            addr_q <= seg_addr;
            rem_q  <= seg_len;
            last_q <= seg_last;
            alt_q  <= alt_mode;
        end else if (do_push) begin
            addr_q <= addr_q + {15'd0, chunk};
            rem_q  <= rem_q - LEN_W'(chunk);
        end
    end

    // Entry counter, cleared after each report.
    always_ff @(posedge clk) begin
        if (!rst_n || do_clear) cnt_q <= '0;
        else if (do_push)       cnt_q <= cnt_q + 1'b1;
    end

    // Result flags: end-of-table and failure.
    always_ff @(posedge clk) begin
        if (!rst_n || do_clear) begin
            fin_q  <= 1'b0;
            fail_q <= 1'b0;
        end else if (state_q == ST_SPLIT) begin
            if (rem_zero && last_q && has_pend)  fin_q  <= 1'b1;
            if (rem_zero && last_q && !has_pend) fail_q <= 1'b1;
            if (!rem_zero && at_limit)           fail_q <= 1'b1;
        end
    end

    // Result outputs, meaningful in the done cycle.
    always_comb begin
        done        = (state_q == ST_DONE);
        fail        = done && fail_q;
        entry_count = (done && !fail_q) ? cnt_q : '0;
    end
endmodule

// File: rtl/prd_table_gen_chk.sv
// Module: prd_table_gen_chk
// Assertion checker for prd_table_gen, attached by bind below.
module prd_table_gen_chk #(
    parameter int MAX_ENTRIES = 256,
    parameter int CNT_W       = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seg_ready,
    input logic             desc_valid,
    input logic             desc_ready,
    input logic [31:0]      desc_word,
    input logic             done,
    input logic             fail,
    input logic [CNT_W-1:0] entry_count
);
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_word)); // R9

    AST_NO_IN_DURING_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_ready && desc_valid)); // R9

    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && fail |-> entry_count == '0); // R6

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> entry_count <= CNT_W'(MAX_ENTRIES)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_OK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fail |-> entry_count != '0); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !desc_valid && !seg_ready); // R8
endmodule

bind prd_table_gen prd_table_gen_chk #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_ready   (seg_ready),
    .desc_valid  (desc_valid),
    .desc_ready  (desc_ready),
    .desc_word   (desc_word),
    .done        (done),
    .fail        (fail),
    .entry_count (entry_count)
);

// File: tb/prd_table_gen_test.sv
// Directed bench for prd_table_gen with a small entry limit.
module prd_table_gen_test;
    localparam int MAXE = 8;
    localparam int CW   = $clog2(MAXE + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alt_mode = 1'b0;
    logic          seg_valid = 1'b0;
    logic          seg_ready;
    logic [31:0]   seg_addr = '0;
    logic [31:0]   seg_len = '0;
    logic          seg_last = 1'b0;
    logic          desc_valid;
    logic          desc_ready = 1'b0;
    logic [31:0]   desc_word;
    logic          done;
    logic          fail;
    logic [CW-1:0] entry_count;

    int checks = 0;
    int errors = 0;

    logic [31:0] sa [0:15];
    logic [31:0] sl [0:15];
    int          ns;
    logic [31:0] ew [0:63];
    logic [31:0] rw [0:63];
    int          ec;
    bit          mf;

    always #4 clk = ~clk;

    prd_table_gen #(.MAX_ENTRIES(MAXE)) uut (
        .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last), .desc_valid(desc_valid),
        .desc_ready(desc_ready), .desc_word(desc_word), .done(done),
        .fail(fail), .entry_count(entry_count)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic add_entry(input logic [31:0] a, input logic [31:0] c);
        if (ec == MAXE) mf = 1;
        else begin
            ew[2*ec] = a; ew[2*ec+1] = c; ec++;
        end
    endtask

    // Reference: descriptor list from the requirements.
    task automatic model(input bit alt);
        ec = 0; mf = 0;
        for (int i = 0; i < ns; i++) begin
            logic [31:0] a, l, b;
            a = sa[i]; l = sl[i];
            while (l != 0 && !mf) begin
                b = 32'h10000 - (a & 32'hFFFF);
                if (b > l) b = l;
                if (!alt && b == 32'h10000) begin
                    add_entry(a, 32'h8000);
                    add_entry(a + 32'h8000, 32'h8000);
                end else if (alt) add_entry(a, ((b >> 2) - 1) << 16);
                else add_entry(a, b);
                a = a + b; l = l - b;
            end
        end
        if (ec == 0) mf = 1;
        if (!mf) ew[2*ec-1][31] = 1'b1;
    endtask

    // Runs one request and compares everything against the model.
    task automatic do_req(input bit alt, input bit stall, input string rq);
        int si = 0, nr = 0, cyc = 0;
        bit took = 0, pstall = 0, fin = 0, gfail = 0;
        logic [31:0] pw = '0;
        int gcnt = 0;
        model(alt);
        alt_mode = alt;
        while (!fin && cyc < 5000) begin
            @(negedge clk); cyc++;
            if (took) si++;
            seg_valid  = (si < ns);
            seg_addr   = sa[(si < ns) ? si : 0];
            seg_len    = sl[(si < ns) ? si : 0];
            seg_last   = (si == ns - 1);
            desc_ready = stall ? (cyc % 3 != 0) : 1'b1;
            #1;
            took = seg_valid && seg_ready;
            if (pstall) chk(desc_valid && desc_word == pw, "R9 held word", desc_word, pw);
            pstall = desc_valid && !desc_ready;
            pw = desc_word;
            if (desc_valid && desc_ready) begin
                if (nr < 64) rw[nr] = desc_word;
                nr++;
            end
            if (done) begin
                fin = 1; gfail = fail; gcnt = int'(entry_count);
            end
        end
        seg_valid = 1'b0;
        chk(fin, {rq, " done seen"}, 32'(fin), 32'd1);
        chk(gfail == mf, {rq, " fail flag"}, 32'(gfail), 32'(mf));
        chk(gcnt == (mf ? 0 : ec), {rq, " R8 entry count"}, 32'(gcnt), 32'(mf ? 0 : ec));
        chk(si == ns, {rq, " segments consumed"}, 32'(si), 32'(ns));
        if (!mf) begin
            chk(nr == 2 * ec, {rq, " word total"}, 32'(nr), 32'(2 * ec));
            for (int k = 0; k < 2 * ec && k < nr; k++)
                chk(rw[k] == ew[k], {rq, " R1 word"}, rw[k], ew[k]);
        end
        @(negedge clk); #1;
        chk(!done, "R8 done single cycle", 32'(done), 32'd0);
    endtask

    task automatic test_reset();
        chk(seg_ready == 1'b1, "R10 seg_ready", 32'(seg_ready), 32'd1);
        chk(!desc_valid, "R10 desc_valid", 32'(desc_valid), 32'd0);
        chk(!done && !fail, "R10 done/fail", 32'({done, fail}), 32'd0);
    endtask

    task automatic test_single();
        ns = 1; sa[0] = 32'h1000_0010; sl[0] = 32'h200;
        do_req(0, 0, "R1 R5 single");
        chk(ew[1] == 32'h8000_0200, "R5 end bit value", ew[1], 32'h8000_0200);
    endtask

    task automatic test_boundary();
        ns = 1; sa[0] = 32'h0001_FF00; sl[0] = 32'h300;
        do_req(0, 0, "R2 boundary");
        chk(ec == 2 && ew[2] == 32'h0002_0000, "R2 split point", ew[2], 32'h0002_0000);
    endtask

    task automatic test_full64();
        ns = 2; sa[0] = 32'h0003_0000; sl[0] = 32'h10000;
        sa[1] = 32'h0005_0000; sl[1] = 32'h18000;
        do_req(0, 1, "R3 full 64K");
        chk(ew[3] == 32'h0000_8000, "R3 half count", ew[3], 32'h0000_8000);
    endtask

    task automatic test_alt();
        ns = 2; sa[0] = 32'h0004_FFF0; sl[0] = 32'h40;
        sa[1] = 32'h0007_0000; sl[1] = 32'h10000;
        do_req(1, 0, "R4 alt mode");
        chk(ec == 3 && ew[1] == 32'h0003_0000, "R4 count encode", ew[1], 32'h0003_0000);
    endtask

    task automatic test_multi_stall();
        ns = 3; sa[0] = 32'h2000_0004; sl[0] = 32'h10;
        sa[1] = 32'h3000_0000; sl[1] = 32'h0;
        sa[2] = 32'h4000_FFFE; sl[2] = 32'h4;
        do_req(0, 1, "R5 R7 R9 multi");
    endtask

    task automatic test_empty();
        ns = 2; sa[0] = 32'h5000_0000; sl[0] = 0; sa[1] = 32'h6000_0000; sl[1] = 0;
        do_req(0, 0, "R7 empty");
        chk(mf == 1'b1, "R7 model fail", 32'(mf), 32'd1);
    endtask

    task automatic test_exact_limit();
        ns = 1; sa[0] = 32'h0010_0000; sl[0] = 32'h40000;
        do_req(0, 0, "R6 exact limit");
        chk(ec == MAXE && !mf, "R6 limit success", 32'(ec), 32'(MAXE));
    endtask

    task automatic test_overflow();
        ns = 3; sa[0] = 32'h0010_0000; sl[0] = 32'h48000;
        sa[1] = 32'h0020_0000; sl[1] = 32'h100;
        sa[2] = 32'h0030_0000; sl[2] = 32'h100;
        do_req(0, 1, "R6 overflow");
        chk(mf == 1'b1, "R6 model fail", 32'(mf), 32'd1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        test_reset();
        test_single();
        test_boundary();
        test_full64();
        test_alt();
        test_multi_stall();
        test_empty();
        test_exact_limit();
        test_overflow();
        test_single();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule